// File: doc/BRIEF.md
# Upgrade Replay Buffer for Speculative Commit

This block keeps a short, ordered list of cache line addresses that an epoch wrote speculatively while the line was still held shared. Such a line has to gain exclusive ownership before the epoch's speculative data can become permanent. The cache controller presents each such line once, on the cycle it first becomes speculatively modified in the shared state, together with the epoch number of the writer. The block drops a repeat of an address it already holds. An insert that arrives with no free slot raises an overflow flag, which the cache treats as a failed speculation.

When the homefree token reaches the epoch, the block replays its contents as upgrade requests. It issues one request per stored line, oldest first, on a valid/ready interface, and each request carries the stored epoch number. An entry leaves the buffer only when its handshake completes. When nothing is left, the block raises a one-cycle completion pulse, so that commit never needs to walk the whole cache looking for lines in speculative states. A violation input discards every entry at once and cancels any replay in progress, without issuing anything.

Top module: `upgrade_replay_buf`

## Requirements
- R1: During and straight after reset the buffer is empty and `up_valid`, `spill` and `replay_done` are all low.
- R2: An insert (`mark_valid` high) of an address not yet held, with fewer than DEPTH entries stored and `squash` low, stores the address with its `mark_epoch`. The address is later issued as an upgrade request with that epoch.
- R3: An insert of a new address while DEPTH entries are held drives `spill` high in that same cycle, and the address is not stored. `spill` is low in every other case.
- R4: An insert of an address already held is ignored. No entry is added, `spill` stays low, and that address is issued only once.
- R5: Before homefree, `up_valid` stays low whatever the buffer holds.
- R6: From the cycle after `homefree` is high, `up_valid` is high while entries remain. `up_addr` and `up_epoch` show the oldest entry. An entry is removed only in a cycle with `up_valid` and `up_ready` both high. While `up_ready` is low the request holds still.
- R7: `replay_done` is high for exactly one cycle. It rises in the cycle after the handshake that removes the last entry. If the buffer is empty when `homefree` is high, it rises in the next cycle.
- R8: A cycle with `squash` high empties the buffer and ends any replay. From the next cycle no request is issued and no `replay_done` follows until a new `homefree`.
- R9: The buffer holds DEPTH (default 8) entries. The (DEPTH+1)th distinct insert without an intervening removal spills.
- R10: Inserts accepted during a replay are queued behind the older entries and issued in the same replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_valid | input | 1 | A line became speculatively modified while shared |
| mark_addr | input | ADDR_W | Line address of that line |
| mark_epoch | input | EPOCH_W | Epoch number of the writer |
| homefree | input | 1 | Homefree token arrived; start replay |
| squash | input | 1 | Violation: discard all entries, no requests |
| up_valid | output | 1 | Upgrade request valid |
| up_ready | input | 1 | Upgrade request accepted |
| up_addr | output | ADDR_W | Line address to upgrade |
| up_epoch | output | EPOCH_W | Epoch number carried with the request |
| spill | output | 1 | Insert refused because the buffer is full |
| replay_done | output | 1 | One-cycle pulse: replay finished |

## Verification
The bench builds the block with its defaults: DEPTH 8, a 32-bit address and an 8-bit epoch. Random addresses are drawn from a pool of twelve lines, so repeat inserts, full-buffer spills, back-to-back replays and wrap-around of the slot pointers all happen often. Because the depth is only eight, the directed fill-to-capacity and the spill of the ninth line take only a few cycles. Random ready stalls test that a waiting request stays fixed, and rare squash pulses arrive in the middle of both filling and replay.

// File: rtl/upgrade_replay_buf.sv
module upgrade_replay_buf #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int EPOCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mark_valid,
  input  logic [ADDR_W-1:0]  mark_addr,
  input  logic [EPOCH_W-1:0] mark_epoch,
  input  logic               homefree,
  input  logic               squash,
  output logic               up_valid,
  input  logic               up_ready,
  output logic [ADDR_W-1:0]  up_addr,
  output logic [EPOCH_W-1:0] up_epoch,
  output logic               spill,
  output logic               replay_done
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0]  addr_q [DEPTH];
  logic [EPOCH_W-1:0] ep_q   [DEPTH];
  logic [DEPTH-1:0]   live_q, hit;
  logic [PTR_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               replay_q;
  logic               dup, full, push, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = live_q[i] && (addr_q[i] == mark_addr);
  end

  assign dup         = |hit;
  assign full        = (cnt_q == FULL_CNT);
  assign push        = mark_valid && !dup && !full && !squash;
  assign pop         = up_valid && up_ready;
  assign up_valid    = replay_q && (cnt_q != '0);
  assign up_addr     = addr_q[head_q];
  assign up_epoch    = ep_q[head_q];
  assign spill       = mark_valid && full && !dup && !squash;
  assign replay_done = replay_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= mark_addr;
      ep_q[tail_q]   <= mark_epoch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      live_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      replay_q <= 1'b0;
    end else begin
      if (push) begin
        live_q[tail_q] <= 1'b1;
        tail_q         <= bump(tail_q);
      end
      if (pop) begin
        live_q[head_q] <= 1'b0;
        head_q         <= bump(head_q);
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (homefree)         replay_q <= 1'b1;
      else if (replay_done) replay_q <= 1'b0;
    end
  end

  p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spill && !pop |=> cnt_q == $past(cnt_q));

  p_dup_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid && dup && !pop && !squash |=> cnt_q == $past(cnt_q));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_ready && !squash |=> up_valid && $stable(up_addr) && $stable(up_epoch));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_done && !homefree |=> !replay_done);

  p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !up_valid && !replay_done && (cnt_q == '0));
endmodule

// File: tb/upgrade_replay_buf_tb_top.sv
module upgrade_replay_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mark_valid = 1'b0, homefree = 1'b0, squash = 1'b0, up_ready = 1'b0;
  logic [31:0] mark_addr = '0;
  logic [7:0]  mark_epoch = '0;
  logic        up_valid, spill, replay_done;
  logic [31:0] up_addr;
  logic [7:0]  up_epoch;

  int vectors = 0, errors = 0;
  logic [31:0] mq_a[$];
  logic [7:0]  mq_e[$];
  bit          mrep = 1'b0;
  logic [31:0] got[$];
  bit o_valid, o_done, o_spill;

  always #5 clk = ~clk;

  upgrade_replay_buf #(.DEPTH(8), .ADDR_W(32), .EPOCH_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mark_valid(mark_valid), .mark_addr(mark_addr),
    .mark_epoch(mark_epoch), .homefree(homefree), .squash(squash),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_epoch(up_epoch), .spill(spill), .replay_done(replay_done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit held(input logic [31:0] a);
    foreach (mq_a[i]) if (mq_a[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit iv, input logic [31:0] ia, input logic [7:0] ie,
                      input bit hf, input bit sq, input bit rd);
    bit e_valid, e_done, e_spill, dp, fl;
    @(negedge clk);
    mark_valid = iv; mark_addr = ia; mark_epoch = ie;
    homefree = hf; squash = sq; up_ready = rd;
    #1;
    dp = held(ia);
    fl = (mq_a.size() == 8);
    e_valid = mrep && (mq_a.size() != 0);
    e_done  = mrep && (mq_a.size() == 0);
    e_spill = iv && fl && !dp && !sq;
    o_valid = up_valid; o_done = replay_done; o_spill = spill;
    chk(up_valid == e_valid, "R6 up_valid", 32'(up_valid), 32'(e_valid));
    chk(replay_done == e_done, "R7 replay_done", 32'(replay_done), 32'(e_done));
    chk(spill == e_spill, "R3 spill", 32'(spill), 32'(e_spill));
    if (e_valid && up_valid) begin
      chk(up_addr == mq_a[0], "R6 up_addr order", up_addr, mq_a[0]);
      chk(up_epoch == mq_e[0], "R2 up_epoch", 32'(up_epoch), 32'(mq_e[0]));
    end
    if (up_valid && rd) got.push_back(up_addr);
    if (sq) begin
      mq_a.delete(); mq_e.delete(); mrep = 1'b0;
    end else begin
      if (e_valid && rd) begin
        void'(mq_a.pop_front()); void'(mq_e.pop_front());
      end
      if (iv && !dp && !fl) begin
        mq_a.push_back(ia); mq_e.push_back(ie);
      end
      if (hf) mrep = 1'b1;
      else if (e_done) mrep = 1'b0;
    end
  endtask

  task automatic idle(input bit rd);
    step(1'b0, '0, '0, 1'b0, 1'b0, rd);
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (2) @(negedge clk);
    #1;
    chk(!up_valid && !spill && !replay_done, "R1 reset outputs quiet", {up_valid, spill, replay_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b1);
    chk(!o_valid && !o_done, "R1 after reset", {o_valid, o_done}, 0);

    // R7: homefree with empty buffer -> done next cycle
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
    chk(!o_done, "R7 no done in homefree cycle", o_done, 0);
    idle(1'b1);
    chk(o_done, "R7 empty homefree done next cycle", o_done, 1);
    idle(1'b1);
    chk(!o_done, "R7 done single cycle", o_done, 0);

    // R9/R5: fill eight lines, no requests before homefree
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 32'h100 + 32'(i) * 32'h40, 8'(i + 3), 1'b0, 1'b0, 1'b1);
      chk(!o_valid, "R5 no request before homefree", o_valid, 0);
      chk(!o_spill, "R9 no spill below capacity", o_spill, 0);
    end
    step(1'b1, 32'h100, 8'h77, 1'b0, 1'b0, 1'b1);
    chk(!o_spill, "R4 duplicate no spill", o_spill, 0);
    step(1'b1, 32'h800, 8'h11, 1'b0, 1'b0, 1'b1);
    chk(o_spill, "R9 ninth line spills", o_spill, 1);

    // replay with stalls, plus an insert during replay (R10)
    got.delete();
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    chk(o_valid, "R6 request after homefree", o_valid, 1);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 32'h900, 8'h21, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 30 && !o_done; i++) idle(i % 3 != 0);
    chk(got.size() == 9, "R4 R10 request count", got.size(), 9);
    if (got.size() == 9) begin
      for (int i = 0; i < 8; i++)
        chk(got[i] == 32'h100 + 32'(i) * 32'h40, "R2 R6 replay order", got[i], 32'h100 + 32'(i) * 32'h40);
      chk(got[8] == 32'h900, "R10 late insert last", got[8], 32'h900);
    end
    chk(o_done, "R7 done after last handshake", o_done, 1);

    // R8: squash discards entries and replay
    for (int i = 0; i < 3; i++) step(1'b1, 32'hA00 + 32'(i), 8'h5, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
    idle(1'b1);
    chk(!o_valid && !o_done, "R8 squash silences replay", {o_valid, o_done}, 0);
    step(1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
    idle(1'b1);
    chk(o_done && !o_valid, "R8 buffer empty after squash", {o_valid, o_done}, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit iv, hf, sq, rd;
      iv = ($urandom_range(99) < 45);
      hf = ($urandom_range(99) < 4);
      sq = ($urandom_range(299) == 0);
      rd = ($urandom_range(99) < 60);
      step(iv, 32'h2000 + 32'($urandom_range(11)) * 32'h40, 8'($urandom), hf, sq, rd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule